// File: doc/BRIEF.md
# Dual-Rail Return-to-Zero Logic Word

This block evaluates a two-input logic function bit by bit on a word of dual-rail operands and produces a dual-rail result. Each bit travels on a true rail and a false rail. A bit is null when both rails are low, zero when only the false rail is high, and one when only the true rail is high. The code with both rails high is never produced.

Each result bit signals its own completion. It leaves null only after both of its operand bits have become valid. It then keeps its value until both operand bits have gone back to null, and only then does it return to null. Operands may therefore arrive and depart in any order without glitching the result. Inside, each bit has four hysteresis cells, one for each pairing of an `a` rail with a `b` rail. These cells are modelled as clocked set/hold/clear elements. A function select chooses how the four cells merge onto the output rails: OR, AND or XOR. Every bit of the word handshakes on its own.

Top module: `dr_logic_word`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, every result bit is null (`y_t` = 0 and `y_f` = 0).
- R2: Per bit, (`y_t`,`y_f`) = (0,0) means null, (0,1) means zero and (1,0) means one. The result never shows (1,1).
- R3: A null result bit becomes valid on the clock edge after the edge at which both of its operand bits are first seen valid. While only one operand bit is valid, the result bit stays null.
- R4: A valid result bit keeps its value, whatever the order of departure, as long as at least one of its operand bits is still valid and `op_sel` is held.
- R5: A valid result bit returns to null on the clock edge after the edge at which both operand bits are seen null.
- R6: With `op_sel` = 2'b00, a valid result bit is `a` OR `b`.
- R7: With `op_sel` = 2'b01, a valid result bit is `a` AND `b`.
- R8: With `op_sel` = 2'b10 or 2'b11, a valid result bit is `a` XOR `b`.
- R9: Each bit position handshakes on its own. A bit may be valid while its neighbours are null, and the other bits do not change its arrival or its hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock that samples the hysteresis cells |
| rst_n | input | 1 | Asynchronous active-low reset; clears every cell |
| op_sel | input | 2 | Function select: 00 OR, 01 AND, 1x XOR |
| a_t | input | WIDTH | True rails of operand a |
| a_f | input | WIDTH | False rails of operand a |
| b_t | input | WIDTH | True rails of operand b |
| b_f | input | WIDTH | False rails of operand b |
| y_t | output | WIDTH | True rails of the result |
| y_f | output | WIDTH | False rails of the result |

## Verification
There is exactly one register between an operand change and the result. An arrival, a hold or a departure seen at one rising edge appears on `y_t`/`y_f` right after that same edge. The bench changes operands on the falling edge. It updates its behavioural model at the next rising edge and compares the whole word at the falling edge after that, once per cycle. Operands are raised and dropped in staggered, per-bit random orders. Directed sequences also step a single bit through one-valid, both-valid, one-departed and both-null states and check the result after each step.

// File: rtl/dr_pkg.sv
package dr_pkg;

    typedef struct packed {
        logic t;
        logic f;
    } rail_t;

    typedef enum logic [1:0] {
        OP_OR  = 2'b00,
        OP_AND = 2'b01,
        OP_XOR = 2'b10,
        OP_XRA = 2'b11
    } op_e;

    localparam int N_MINTERM = 4;

endpackage

// File: rtl/dr_celem.sv
module dr_celem (
    input  logic clk,
    input  logic rst_n,
    input  logic x,
    input  logic y,
    output logic q
);

    typedef struct packed {
        logic q;
    } cel_state_t;

    cel_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (x && y) begin
            st_d.q = 1'b1;
        end else if (!x && !y) begin
            st_d.q = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q.q;

    // both inputs high -> set
    assert_cel_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (x && y) |=> q);

    // both inputs low -> clear
    assert_cel_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!x && !y) |=> !q);

    // disagreeing inputs -> hold
    assert_cel_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (x != y) |=> $stable(q));

endmodule

// File: rtl/dr_gate_bit.sv
module dr_gate_bit
    import dr_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  op_e   op,
    input  rail_t a,
    input  rail_t b,
    output rail_t y
);

    // m[k]: cell k pairs a rail (k[1]: 1 true, 0 false) with b rail (k[0])
    logic [N_MINTERM-1:0] m;

    for (genvar k = 0; k < N_MINTERM; k++) begin : g_cell
        localparam logic SEL_A = 1'((k >> 1) & 1);
        localparam logic SEL_B = 1'(k & 1);
        dr_celem u_cel (
            .clk   (clk),
            .rst_n (rst_n),
            .x     (SEL_A ? a.t : a.f),
            .y     (SEL_B ? b.t : b.f),
            .q     (m[k])
        );
    end

    always_comb begin
        y = '0;
        unique case (op)
            OP_OR: begin
                y.t = m[3] | m[2] | m[1];
                y.f = m[0];
            end
            OP_AND: begin
                y.t = m[3];
                y.f = m[2] | m[1] | m[0];
            end
            default: begin
                y.t = m[2] | m[1];
                y.f = m[3] | m[0];
            end
        endcase
    end

    logic a_null, b_null, a_val, b_val, y_val;
    assign a_null = !a.t && !a.f;
    assign b_null = !b.t && !b.f;
    assign a_val  = a.t ^ a.f;
    assign b_val  = b.t ^ b.f;
    assign y_val  = y.t | y.f;

    assert_no_both_rails_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(y.t && y.f));

    assert_arrive_needs_both_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(y_val) |-> $past(a_val && b_val));

    assert_hold_until_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (y_val && !(a_null && b_null)) |=> (!$stable(op) || $stable(y)));

    assert_return_null_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (a_null && b_null) |=> !y_val);

endmodule

// File: rtl/dr_logic_word.sv
module dr_logic_word
    import dr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       op_sel,
    input  logic [WIDTH-1:0] a_t,
    input  logic [WIDTH-1:0] a_f,
    input  logic [WIDTH-1:0] b_t,
    input  logic [WIDTH-1:0] b_f,
    output logic [WIDTH-1:0] y_t,
    output logic [WIDTH-1:0] y_f
);

    op_e op;
    assign op = op_e'(op_sel);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        rail_t a_r, b_r, y_r;
        assign a_r = '{t: a_t[i], f: a_f[i]};
        assign b_r = '{t: b_t[i], f: b_f[i]};

        dr_gate_bit u_bit (
            .clk   (clk),
            .rst_n (rst_n),
            .op    (op),
            .a     (a_r),
            .b     (b_r),
            .y     (y_r)
        );

        assign y_t[i] = y_r.t;
        assign y_f[i] = y_r.f;
    end

    // R1: no result rail is high in the cycle after reset release
    assert_reset_null_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (y_t == '0 && y_f == '0));

endmodule

// File: tb/dr_logic_word_tb.sv
module dr_logic_word_tb;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   op_sel = 2'b00;
    logic [W-1:0] a_t = '0, a_f = '0, b_t = '0, b_f = '0;
    logic [W-1:0] y_t, y_f;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    // model state per bit
    bit mv [W];
    bit mval [W];

    always #2 clk = ~clk;

    dr_logic_word #(.WIDTH(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_sel(op_sel),
        .a_t(a_t), .a_f(a_f), .b_t(b_t), .b_f(b_f),
        .y_t(y_t), .y_f(y_f)
    );

    function automatic bit fn(input logic [1:0] op, input bit x, input bit y);
        if (op == 2'b00) return x | y;
        if (op == 2'b01) return x & y;
        return x ^ y;
    endfunction

    task automatic compare(input string tag);
        logic [W-1:0] et, ef;
        for (int i = 0; i < W; i++) begin
            et[i] = mv[i] & mval[i];
            ef[i] = mv[i] & ~mval[i];
        end
        vectors++;
        if (y_t !== et || y_f !== ef) begin
            fails++;
            $display("FAIL %s: y_t=%b y_f=%b expected y_t=%b y_f=%b", tag, y_t, y_f, et, ef);
        end
        vectors++;
        if ((y_t & y_f) !== '0) begin
            fails++;
            $display("FAIL R2: both rails high y_t=%b y_f=%b expected no overlap", y_t, y_f);
        end
    endtask

    task automatic step(input string tag);
        @(posedge clk);
        for (int i = 0; i < W; i++) begin
            bit an, bn, av, bv;
            an = !a_t[i] && !a_f[i];
            bn = !b_t[i] && !b_f[i];
            av = a_t[i] ^ a_f[i];
            bv = b_t[i] ^ b_f[i];
            if (!mv[i] && av && bv) begin
                mv[i] = 1'b1;
                mval[i] = fn(op_sel, a_t[i], b_t[i]);
            end else if (an && bn) begin
                mv[i] = 1'b0;
            end
        end
        @(negedge clk);
        compare(tag);
    endtask

    task automatic setbit(input int i, input bit is_a, input int code);
        // code: 0 null, 1 zero, 2 one
        if (is_a) begin
            a_t[i] = (code == 2); a_f[i] = (code == 1);
        end else begin
            b_t[i] = (code == 2); b_f[i] = (code == 1);
        end
    endtask

    task automatic expect_bit(input int i, input bit t, input bit f, input string tag);
        vectors++;
        if (y_t[i] !== t || y_f[i] !== f) begin
            fails++;
            $display("FAIL %s: bit%0d rails=%b%b expected %b%b", tag, i, y_t[i], y_f[i], t, f);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin : stim
        bit fill [W];
        string optag;
        for (int i = 0; i < W; i++) begin mv[i] = 0; mval[i] = 0; fill[i] = 1; end
        repeat (3) @(negedge clk);
        compare("R1 during reset");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1 after release");

        // directed staggered sequence on bit 0, OR
        op_sel = 2'b00;
        setbit(0, 1, 2); step("R3 one input only");
        expect_bit(0, 0, 0, "R3 one input only");
        setbit(0, 0, 1); step("R3 both valid");
        expect_bit(0, 1, 0, "R6 one OR zero");
        setbit(0, 1, 0); step("R4 a departed");
        expect_bit(0, 1, 0, "R4 hold after a departed");
        // R9: bit 1 arrives while bit 0 holds
        setbit(1, 0, 1); setbit(1, 1, 1); step("R9 neighbour arrives");
        expect_bit(1, 0, 1, "R9 bit1 zero OR zero");
        expect_bit(0, 1, 0, "R9 bit0 undisturbed");
        setbit(0, 0, 0); step("R5 both null");
        expect_bit(0, 0, 0, "R5 bit0 back to null");
        expect_bit(1, 0, 1, "R9 bit1 still valid");
        setbit(1, 0, 0); setbit(1, 1, 0); step("R5 bit1 null");
        expect_bit(1, 0, 0, "R5 bit1 back to null");

        // AND directed, b first, b departs first
        op_sel = 2'b01;
        setbit(2, 0, 2); step("R3 b only");
        expect_bit(2, 0, 0, "R3 b only");
        setbit(2, 1, 2); step("R7 both valid");
        expect_bit(2, 1, 0, "R7 one AND one");
        setbit(2, 0, 0); step("R4 b departed");
        expect_bit(2, 1, 0, "R4 hold after b departed");
        setbit(2, 1, 0); step("R5 null");
        expect_bit(2, 0, 0, "R5 null");

        // XOR directed
        op_sel = 2'b11;
        setbit(3, 0, 2); setbit(3, 1, 2); step("R8 both valid");
        expect_bit(3, 0, 1, "R8 one XOR one");
        setbit(3, 0, 0); setbit(3, 1, 0); step("R5 null");

        // random staggered traffic for each function
        for (int opi = 0; opi < 4; opi++) begin
            op_sel = 2'(opi);
            optag = (opi == 0) ? "R6" : (opi == 1) ? "R7" : "R8";
            for (int c = 0; c < 300; c++) begin
                for (int i = 0; i < W; i++) begin
                    bit an, bn;
                    an = !a_t[i] && !a_f[i];
                    bn = !b_t[i] && !b_f[i];
                    if (mv[i]) fill[i] = 0;
                    else if (an && bn) fill[i] = 1;
                    if (fill[i]) begin
                        if (an && $urandom_range(1)) setbit(i, 1, 1 + $urandom_range(1));
                        if (bn && $urandom_range(1)) setbit(i, 0, 1 + $urandom_range(1));
                    end else begin
                        if (!an && $urandom_range(1)) setbit(i, 1, 0);
                        if (!bn && $urandom_range(1)) setbit(i, 0, 0);
                    end
                end
                step(optag);
            end
            a_t = '0; a_f = '0; b_t = '0; b_f = '0;
            step("R5 drain");
            step("R5 drain");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule